// File: doc/BRIEF.md
# Address-Space Tagged Translation Cache with Selective Invalidation

This block is a small fully associative translation cache that sits beside a page-table walker. Each line holds an address-space identifier, a 20-bit virtual page number (4 KiB pages, so the page number is virtual address bits [31:12]), a physical frame number and three permission flags (read, write, nonsecure). A lookup presents an identifier and a 32-bit virtual address and gets hit, frame and flags back combinationally in the same cycle. After a miss the walker installs the translation through the refill port.

Invalidation is driven by a single 32-bit command word. The word selects an address criterion: every address, one 4 MiB section, or one 16 KiB group of four pages. It can also restrict the effect to a single identifier. The identifier field sits at a different bit position when the block is built for 4 identifiers rather than 128. Three configuration inputs set the number of active lines, choose rotating or fixed victim selection, and allow lookups that hit to go on while a miss is waiting for its refill.

The lookup and refill ports use valid/ready. A lookup transfers when `lk_valid` and `lk_ready` are both high. A transfer that misses leaves a refill pending. While a refill is pending, `lk_ready` is low unless hit-under-miss is enabled and the presented lookup hits. `rf_ready` is low only in a cycle that writes a flush command, so a refill offered in that cycle must be held until the next one. The lookup result outputs are valid in any cycle and are consumed only on a transfer.

Top module: `asid_tlb`

## Requirements
- R1: A lookup hits in the same cycle, with that line's frame and flags, only when an active valid line matches both the identifier and address bits [31:12]. Otherwise hit, frame and flags are zero. All lines are invalid after reset.
- R2: A refill accepted at a clock edge is visible to a lookup of the same identifier and page in the next cycle.
- R3: A refill whose identifier and page already sit in an active line overwrites that line, so no key ever matches two lines. Any inactive line holding the same key is invalidated.
- R4: Without a matching line, a refill fills the lowest-numbered free active line. When all active lines are valid, the victim is a rotating pointer if `cfg_rr_en` is 1 and line 0 if it is 0. The pointer advances after each such replacement and wraps at the active count.
- R5: Only lines below the active count take part in lookup and allocation. An active count of 0 acts as 1, and a count above the line total acts as the total.
- R6: Command mode 0 (bits [1:0]=0) invalidates every line if bit 31 is 0, and only lines whose identifier matches the command identifier if bit 31 is 1.
- R7: Mode 2 invalidates lines whose address bits [31:22] equal command bits [19:10], qualified by identifier when bit 31 is 1.
- R8: Mode 3 invalidates lines whose address bits [31:14] equal command bits [19:2], qualified by identifier when bit 31 is 1.
- R9: With 128 identifiers the command identifier is bits [30:24]. With 4 identifiers it is bits [30:29], and bits [28:24] are ignored.
- R10: Mode 1 leaves every line unchanged.
- R11: A command written in one cycle takes effect at that clock edge. A lookup in the same cycle still sees the old contents, and `rf_ready` is 0 in that cycle.
- R12: After an accepted missing lookup, `lk_ready` is 0 until a refill is accepted, except that with `cfg_hum` set a lookup that hits keeps `lk_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_active_lines | input | CNT_W | Number of lines in use |
| cfg_rr_en | input | 1 | Rotating victim selection when all lines are full |
| cfg_hum | input | 1 | Let hitting lookups proceed while a refill is pending |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted |
| lk_asid | input | ASID_W | Lookup identifier |
| lk_va | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Lookup hit |
| lk_pfn | output | PFN_W | Physical frame on hit |
| lk_rd | output | 1 | Read permission on hit |
| lk_wr | output | 1 | Write permission on hit |
| lk_ns | output | 1 | Nonsecure flag on hit |
| rf_valid | input | 1 | Refill valid |
| rf_ready | output | 1 | Refill accepted |
| rf_asid | input | ASID_W | Refill identifier |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_pfn | input | PFN_W | Refill physical frame |
| rf_rd | input | 1 | Refill read permission |
| rf_wr | input | 1 | Refill write permission |
| rf_ns | input | 1 | Refill nonsecure flag |
| flush_wr | input | 1 | Flush command write strobe |
| flush_cmd | input | 32 | Flush command word |

## Verification
The properties assume that `rf_valid` is low while reset is held. They also assume that every input has a known value at each clock edge. The refill-visibility property further assumes that the active-line count does not change between a refill and the lookup that follows it. The stimulus drives all inputs to defined values from time zero and keeps the refill port idle during reset. It changes `cfg_active_lines` only between test phases, and it reuses a small key space so that duplicate refills and every flush mode hit lines that are really present.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  localparam int VA_W     = 32;
  localparam int PG_SHIFT = 12;
  localparam int VPN_W    = VA_W - PG_SHIFT;

  typedef enum logic [1:0] {
    SEL_ALL     = 2'd0,
    SEL_NONE    = 2'd1,
    SEL_SECTION = 2'd2,
    SEL_GROUP   = 2'd3
  } fl_sel_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ns;
  } perm_t;

  // page-number bits compared for each address criterion
  localparam logic [VPN_W-1:0] MASK_SECTION = 20'hFFC00;
  localparam logic [VPN_W-1:0] MASK_GROUP   = 20'hFFFFC;
endpackage

// File: rtl/asid_tlb_fdec.sv
module asid_tlb_fdec
  import asid_tlb_pkg::*;
#(
  parameter int NUM_ASIDS = 128,
  parameter int ASID_W    = 7
) (
  input  logic              flush_wr,
  input  logic [31:0]       flush_cmd,
  output logic              fl_go,
  output logic              fl_asid_en,
  output logic [ASID_W-1:0] fl_asid,
  output logic [VPN_W-1:0]  fl_mask,
  output logic [VPN_W-1:0]  fl_tag
);
  fl_sel_e sel;

  assign sel        = fl_sel_e'(flush_cmd[1:0]);
  assign fl_asid_en = flush_cmd[31];
  assign fl_tag     = flush_cmd[19:0];

  generate
    if (NUM_ASIDS == 4) begin : g_asid_narrow
      assign fl_asid = flush_cmd[30:29];
    end else begin : g_asid_wide
      assign fl_asid = flush_cmd[30:24];
    end
  endgenerate

  always_comb begin
    fl_go   = flush_wr;
    fl_mask = '0;
    unique case (sel)
      SEL_ALL:     fl_mask = '0;
      SEL_SECTION: fl_mask = MASK_SECTION;
      SEL_GROUP:   fl_mask = MASK_GROUP;
      default:     fl_go   = 1'b0;
    endcase
  end
endmodule

// File: rtl/asid_tlb_lines.sv
module asid_tlb_lines
  import asid_tlb_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int ASID_W  = 7,
  parameter int PFN_W   = 20,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] act_mask,
  input  logic [ASID_W-1:0]  lk_asid,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic [N_LINES-1:0] hit_vec,
  output logic [PFN_W-1:0]   hit_pfn,
  output perm_t              hit_perm,
  input  logic [ASID_W-1:0]  rf_asid,
  input  logic [VPN_W-1:0]   rf_vpn,
  output logic [N_LINES-1:0] dup_vec,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [PFN_W-1:0]   wr_pfn,
  input  perm_t              wr_perm,
  input  logic               fl_go,
  input  logic               fl_asid_en,
  input  logic [ASID_W-1:0]  fl_asid,
  input  logic [VPN_W-1:0]   fl_mask,
  input  logic [VPN_W-1:0]   fl_tag,
  output logic [N_LINES-1:0] valid_vec
);
  logic [N_LINES-1:0] v_q;
  logic [ASID_W-1:0]  asid_q [N_LINES];
  logic [VPN_W-1:0]   vpn_q  [N_LINES];
  logic [PFN_W-1:0]   pfn_q  [N_LINES];
  perm_t              perm_q [N_LINES];
  logic [N_LINES-1:0] kill_vec;
  logic [N_LINES-1:0] stale_vec;
  logic [N_LINES-1:0] key_vec;

  genvar g;
  generate
    for (g = 0; g < N_LINES; g++) begin : g_line
      assign hit_vec[g]   = act_mask[g] & v_q[g] &
                            (asid_q[g] == lk_asid) & (vpn_q[g] == lk_vpn);
      assign key_vec[g]   = v_q[g] & (asid_q[g] == rf_asid) & (vpn_q[g] == rf_vpn);
      assign dup_vec[g]   = key_vec[g] & act_mask[g];
      assign stale_vec[g] = key_vec[g] & ~act_mask[g];
      assign kill_vec[g]  = v_q[g] & (~fl_asid_en | (asid_q[g] == fl_asid)) &
                            (((vpn_q[g] ^ fl_tag) & fl_mask) == '0);
    end
  endgenerate

  assign valid_vec = v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q <= '0;
      for (int i = 0; i < N_LINES; i++) begin
        asid_q[i] <= '0;
        vpn_q[i]  <= '0;
        pfn_q[i]  <= '0;
        perm_q[i] <= '0;
      end
    end else if (fl_go) begin
      v_q <= v_q & ~kill_vec;
    end else if (wr_en) begin
      for (int i = 0; i < N_LINES; i++) begin
        if (wr_idx == IDX_W'(i)) begin
          v_q[i]    <= 1'b1;
          asid_q[i] <= rf_asid;
          vpn_q[i]  <= rf_vpn;
          pfn_q[i]  <= wr_pfn;
          perm_q[i] <= wr_perm;
        end else if (stale_vec[i]) begin
          v_q[i] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    hit_pfn  = '0;
    hit_perm = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (hit_vec[i]) begin
        hit_pfn  = hit_pfn | pfn_q[i];
        hit_perm = hit_perm | perm_q[i];
      end
    end
  end
endmodule

// File: rtl/asid_tlb_victim.sv
module asid_tlb_victim #(
  parameter int N_LINES = 8,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   eff_act,
  input  logic [N_LINES-1:0] act_mask,
  input  logic [N_LINES-1:0] valid_vec,
  input  logic [N_LINES-1:0] dup_vec,
  input  logic               rr_en,
  input  logic               alloc,
  output logic [IDX_W-1:0]   wr_idx
);
  logic [IDX_W-1:0] ptr_q, ptr_eff, dup_idx, free_idx;
  logic             dup_hit, free_hit;
  logic [CNT_W-1:0] ptr_nxt;

  always_comb begin
    dup_hit = 1'b0;
    dup_idx = '0;
    for (int i = 0; i < N_LINES; i++) begin
      if (dup_vec[i]) begin
        dup_hit = 1'b1;
        dup_idx = IDX_W'(i);
      end
    end
    free_hit = 1'b0;
    free_idx = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (act_mask[i] && !valid_vec[i]) begin
        free_hit = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
    ptr_eff = (CNT_W'(ptr_q) < eff_act) ? ptr_q : '0;
    ptr_nxt = CNT_W'(ptr_eff) + CNT_W'(1);
    if (dup_hit)       wr_idx = dup_idx;
    else if (free_hit) wr_idx = free_idx;
    else if (rr_en)    wr_idx = ptr_eff;
    else               wr_idx = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (alloc && !dup_hit && !free_hit && rr_en) begin
      ptr_q <= (ptr_nxt == eff_act) ? '0 : IDX_W'(ptr_nxt);
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter  int N_LINES   = 8,
  parameter  int NUM_ASIDS = 128,
  parameter  int PFN_W     = 20,
  localparam int ASID_W    = (NUM_ASIDS == 4) ? 2 : 7,
  localparam int IDX_W     = $clog2(N_LINES),
  localparam int CNT_W     = $clog2(N_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_active_lines,
  input  logic              cfg_rr_en,
  input  logic              cfg_hum,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [31:0]       lk_va,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic              lk_rd,
  output logic              lk_wr,
  output logic              lk_ns,
  input  logic              rf_valid,
  output logic              rf_ready,
  input  logic [ASID_W-1:0] rf_asid,
  input  logic [19:0]       rf_vpn,
  input  logic [PFN_W-1:0]  rf_pfn,
  input  logic              rf_rd,
  input  logic              rf_wr,
  input  logic              rf_ns,
  input  logic              flush_wr,
  input  logic [31:0]       flush_cmd
);
  logic [CNT_W-1:0]   eff_act;
  logic [N_LINES-1:0] act_mask;
  logic [N_LINES-1:0] hit_vec, dup_vec, valid_vec;
  logic [IDX_W-1:0]   wr_idx;
  logic               fl_go, fl_asid_en;
  logic [ASID_W-1:0]  fl_asid;
  logic [VPN_W-1:0]   fl_mask, fl_tag;
  perm_t              hit_perm;
  logic               pend_q;
  logic               rf_fire, lk_fire;

  always_comb begin
    if (cfg_active_lines == '0)                      eff_act = CNT_W'(1);
    else if (cfg_active_lines > CNT_W'(N_LINES))     eff_act = CNT_W'(N_LINES);
    else                                             eff_act = cfg_active_lines;
  end

  genvar g;
  generate
    for (g = 0; g < N_LINES; g++) begin : g_act
      assign act_mask[g] = (CNT_W'(g) < eff_act);
    end
  endgenerate

  asid_tlb_fdec #(.NUM_ASIDS(NUM_ASIDS), .ASID_W(ASID_W)) u_fdec (
    .flush_wr   (flush_wr),
    .flush_cmd  (flush_cmd),
    .fl_go      (fl_go),
    .fl_asid_en (fl_asid_en),
    .fl_asid    (fl_asid),
    .fl_mask    (fl_mask),
    .fl_tag     (fl_tag)
  );

  assign rf_ready = ~flush_wr;
  assign rf_fire  = rf_valid & rf_ready;

  asid_tlb_lines #(.N_LINES(N_LINES), .ASID_W(ASID_W), .PFN_W(PFN_W), .IDX_W(IDX_W)) u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_mask   (act_mask),
    .lk_asid    (lk_asid),
    .lk_vpn     (lk_va[VA_W-1:PG_SHIFT]),
    .hit_vec    (hit_vec),
    .hit_pfn    (lk_pfn),
    .hit_perm   (hit_perm),
    .rf_asid    (rf_asid),
    .rf_vpn     (rf_vpn),
    .dup_vec    (dup_vec),
    .wr_en      (rf_fire),
    .wr_idx     (wr_idx),
    .wr_pfn     (rf_pfn),
    .wr_perm    ({rf_rd, rf_wr, rf_ns}),
    .fl_go      (fl_go),
    .fl_asid_en (fl_asid_en),
    .fl_asid    (fl_asid),
    .fl_mask    (fl_mask),
    .fl_tag     (fl_tag),
    .valid_vec  (valid_vec)
  );

  asid_tlb_victim #(.N_LINES(N_LINES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .eff_act   (eff_act),
    .act_mask  (act_mask),
    .valid_vec (valid_vec),
    .dup_vec   (dup_vec),
    .rr_en     (cfg_rr_en),
    .alloc     (rf_fire),
    .wr_idx    (wr_idx)
  );

  assign lk_hit   = |hit_vec;
  assign lk_rd    = hit_perm.rd;
  assign lk_wr    = hit_perm.wr;
  assign lk_ns    = hit_perm.ns;
  assign lk_ready = ~pend_q | (cfg_hum & lk_hit);
  assign lk_fire  = lk_valid & lk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= (pend_q & ~rf_fire) | (lk_fire & ~lk_hit);
  end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk #(
  parameter int N_LINES = 8,
  parameter int ASID_W  = 7,
  parameter int PFN_W   = 20,
  parameter int CNT_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_hum,
  input logic [CNT_W-1:0]   cfg_active_lines,
  input logic               lk_valid,
  input logic               lk_ready,
  input logic               lk_hit,
  input logic [ASID_W-1:0]  lk_asid,
  input logic [31:0]        lk_va,
  input logic [PFN_W-1:0]   lk_pfn,
  input logic               rf_valid,
  input logic               rf_ready,
  input logic [ASID_W-1:0]  rf_asid,
  input logic [19:0]        rf_vpn,
  input logic [PFN_W-1:0]   rf_pfn,
  input logic               flush_wr,
  input logic [31:0]        flush_cmd,
  input logic [N_LINES-1:0] hit_vec
);
  assert_unique_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_refill_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rf_valid && rf_ready) && lk_asid == $past(rf_asid) &&
     lk_va[31:12] == $past(rf_vpn) && $stable(cfg_active_lines))
    |-> (lk_hit && lk_pfn == $past(rf_pfn)));

  assert_flush_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_wr && flush_cmd[1:0] == 2'd0 && !flush_cmd[31]) |=> !lk_hit);

  assert_group_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush_wr && flush_cmd[1:0] == 2'd3 && !flush_cmd[31]) &&
     lk_va[31:14] == $past(flush_cmd[19:2]) && $stable(cfg_active_lines)) |-> !lk_hit);

  assert_miss_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready && !lk_hit && !(rf_valid && rf_ready))
    |=> (lk_ready == (cfg_hum && lk_hit)));
endmodule

bind asid_tlb asid_tlb_chk #(
  .N_LINES(N_LINES), .ASID_W(ASID_W), .PFN_W(PFN_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_hum(cfg_hum), .cfg_active_lines(cfg_active_lines),
  .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_hit(lk_hit), .lk_asid(lk_asid),
  .lk_va(lk_va), .lk_pfn(lk_pfn), .rf_valid(rf_valid), .rf_ready(rf_ready),
  .rf_asid(rf_asid), .rf_vpn(rf_vpn), .rf_pfn(rf_pfn), .flush_wr(flush_wr),
  .flush_cmd(flush_cmd), .hit_vec(hit_vec)
);

// File: tb/asid_tlb_test.sv
module asid_tlb_test;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  cfg_active_lines = 4'd8;
  logic        cfg_rr_en = 1'b1, cfg_hum = 1'b0;
  logic        lk_valid = 1'b0, lk_ready, lk_hit, lk_rd, lk_wr, lk_ns;
  logic [6:0]  lk_asid = '0;
  logic [31:0] lk_va = '0;
  logic [19:0] lk_pfn;
  logic        rf_valid = 1'b0, rf_ready, rf_rd = 1'b0, rf_wr = 1'b0, rf_ns = 1'b0;
  logic [6:0]  rf_asid = '0;
  logic [19:0] rf_vpn = '0, rf_pfn = '0;
  logic        flush_wr = 1'b0;
  logic [31:0] flush_cmd = '0;

  // second build with the narrow identifier field
  logic [2:0]  a_act = 3'd4;
  logic        a_lk_ready, a_lk_hit, a_rd, a_wr, a_ns, a_rf_valid = 1'b0, a_rf_ready;
  logic [1:0]  a_lk_asid = '0, a_rf_asid = '0;
  logic [31:0] a_lk_va = '0;
  logic [19:0] a_lk_pfn, a_rf_vpn = '0, a_rf_pfn = '0;
  logic        a_flush_wr = 1'b0;
  logic [31:0] a_flush_cmd = '0;

  always #10 clk = ~clk;

  asid_tlb #(.N_LINES(N), .NUM_ASIDS(128), .PFN_W(20)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_active_lines(cfg_active_lines), .cfg_rr_en(cfg_rr_en),
    .cfg_hum(cfg_hum), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_asid(lk_asid),
    .lk_va(lk_va), .lk_hit(lk_hit), .lk_pfn(lk_pfn), .lk_rd(lk_rd), .lk_wr(lk_wr),
    .lk_ns(lk_ns), .rf_valid(rf_valid), .rf_ready(rf_ready), .rf_asid(rf_asid),
    .rf_vpn(rf_vpn), .rf_pfn(rf_pfn), .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_ns(rf_ns),
    .flush_wr(flush_wr), .flush_cmd(flush_cmd));

  asid_tlb #(.N_LINES(4), .NUM_ASIDS(4), .PFN_W(20)) uut_a4 (
    .clk(clk), .rst_n(rst_n), .cfg_active_lines(a_act), .cfg_rr_en(1'b1),
    .cfg_hum(1'b1), .lk_valid(1'b0), .lk_ready(a_lk_ready), .lk_asid(a_lk_asid),
    .lk_va(a_lk_va), .lk_hit(a_lk_hit), .lk_pfn(a_lk_pfn), .lk_rd(a_rd), .lk_wr(a_wr),
    .lk_ns(a_ns), .rf_valid(a_rf_valid), .rf_ready(a_rf_ready), .rf_asid(a_rf_asid),
    .rf_vpn(a_rf_vpn), .rf_pfn(a_rf_pfn), .rf_rd(1'b1), .rf_wr(1'b1), .rf_ns(1'b0),
    .flush_wr(a_flush_wr), .flush_cmd(a_flush_cmd));

  int n_tests = 0, n_fail = 0;
  string cur_req = "R1";

  // reference model state
  bit          mv [N];
  logic [6:0]  masid [N];
  logic [19:0] mvpn [N];
  logic [19:0] mpfn [N];
  logic [2:0]  mperm [N];
  int          mptr = 0;
  bit          mpend = 0;

  logic        s_hit, s_rdy;
  logic [19:0] s_pfn;
  logic [2:0]  s_perm;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int m_act();
    if (cfg_active_lines == 0) return 1;
    if (cfg_active_lines > N) return N;
    return int'(cfg_active_lines);
  endfunction

  function automatic int m_find(logic [6:0] a, logic [19:0] v);
    for (int i = 0; i < m_act(); i++)
      if (mv[i] && masid[i] == a && mvpn[i] == v) return i;
    return -1;
  endfunction

  function automatic logic [31:0] mk(bit en, logic [6:0] a, logic [1:0] mode, logic [31:0] va);
    logic [31:0] c = '0;
    c[31] = en; c[30:24] = a; c[1:0] = mode;
    if (mode == 2'd2) c[19:10] = va[31:22];
    if (mode == 2'd3) c[19:2]  = va[31:14];
    return c;
  endfunction

  task automatic tick();
    int idx, act, vic;
    bit e_hit, e_rdy, e_rfr, lk_fire, rf_fire, ok;
    logic [31:0] gotv, expv;
    #8;
    idx   = m_find(lk_asid, lk_va[31:12]);
    e_hit = (idx >= 0);
    e_rdy = !mpend || (cfg_hum && e_hit);
    e_rfr = !flush_wr;
    s_hit = lk_hit; s_rdy = lk_ready; s_pfn = lk_pfn; s_perm = {lk_rd, lk_wr, lk_ns};
    gotv  = {6'd0, lk_hit, lk_ready, rf_ready, lk_rd, lk_wr, lk_ns, lk_pfn};
    expv  = {6'd0, e_hit, e_rdy, e_rfr, e_hit ? mperm[idx] : 3'b000, e_hit ? mpfn[idx] : 20'd0};
    chk(gotv == expv, cur_req, 64'(gotv), 64'(expv));
    @(posedge clk);
    lk_fire = lk_valid && e_rdy;
    rf_fire = rf_valid && e_rfr;
    act = m_act();
    if (flush_wr) begin
      if (flush_cmd[1:0] != 2'd1) begin
        for (int i = 0; i < N; i++) begin
          ok = !flush_cmd[31] || masid[i] == flush_cmd[30:24];
          if (flush_cmd[1:0] == 2'd2) ok = ok && (mvpn[i][19:10] == flush_cmd[19:10]);
          if (flush_cmd[1:0] == 2'd3) ok = ok && (mvpn[i][19:2] == flush_cmd[19:2]);
          if (ok) mv[i] = 0;
        end
      end
    end else if (rf_fire) begin
      vic = m_find(rf_asid, rf_vpn);
      if (vic < 0) begin
        for (int i = act - 1; i >= 0; i--) if (!mv[i]) vic = i;
      end
      if (vic < 0) begin
        if (cfg_rr_en) begin
          vic  = (mptr < act) ? mptr : 0;
          mptr = (vic + 1 == act) ? 0 : vic + 1;
        end else vic = 0;
      end
      for (int i = act; i < N; i++)
        if (mv[i] && masid[i] == rf_asid && mvpn[i] == rf_vpn) mv[i] = 0;
      mv[vic] = 1; masid[vic] = rf_asid; mvpn[vic] = rf_vpn;
      mpfn[vic] = rf_pfn; mperm[vic] = {rf_rd, rf_wr, rf_ns};
    end
    mpend = (mpend && !rf_fire) || (lk_fire && !e_hit);
    @(negedge clk);
  endtask

  task automatic refill(logic [6:0] a, logic [19:0] v, logic [19:0] p, logic [2:0] pm);
    rf_valid = 1; rf_asid = a; rf_vpn = v; rf_pfn = p; {rf_rd, rf_wr, rf_ns} = pm;
    tick();
    rf_valid = 0;
  endtask

  task automatic flush(logic [31:0] c);
    flush_wr = 1; flush_cmd = c;
    tick();
    flush_wr = 0;
  endtask

  task automatic probe(logic [6:0] a, logic [31:0] va, bit e_hit, logic [19:0] e_pfn, string req);
    lk_asid = a; lk_va = va;
    tick();
    chk(s_hit == e_hit && (!e_hit || s_pfn == e_pfn), req,
        64'({s_hit, s_pfn}), 64'({e_hit, e_pfn}));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      mv[i] = 0; masid[i] = '0; mvpn[i] = '0; mpfn[i] = '0; mperm[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state, all lines empty
    cur_req = "R1";
    probe(7'd0, 32'h0, 0, 0, "R1");
    chk(s_rdy == 1'b1, "R1", 64'(s_rdy), 64'd1);

    // R2: install and see the translation next cycle
    cur_req = "R2";
    refill(7'd5, 20'h12345, 20'hABCDE, 3'b101);
    probe(7'd5, 32'h12345678, 1, 20'hABCDE, "R2");
    chk(s_perm == 3'b101, "R2", 64'(s_perm), 64'b101);
    // R1: same page under another identifier misses
    cur_req = "R1";
    probe(7'd6, 32'h12345678, 0, 0, "R1");

    // R3: overwrite in place
    cur_req = "R3";
    refill(7'd5, 20'h12345, 20'h00777, 3'b010);
    probe(7'd5, 32'h12345000, 1, 20'h00777, "R3");

    // R4: fill all lines, then rotating replacement
    cur_req = "R4";
    for (int i = 1; i < N; i++) refill(7'd1, 20'(i), 20'(100 + i), 3'b100);
    refill(7'd2, 20'h00100, 20'h00200, 3'b110);
    probe(7'd5, 32'h12345000, 0, 0, "R4");
    refill(7'd2, 20'h00101, 20'h00201, 3'b110);
    probe(7'd1, 32'h00001000, 0, 0, "R4");
    probe(7'd1, 32'h00002000, 1, 20'd102, "R4");
    cfg_rr_en = 0;
    refill(7'd3, 20'h00300, 20'h00301, 3'b111);
    probe(7'd2, 32'h00100000, 0, 0, "R4");
    refill(7'd3, 20'h00302, 20'h00303, 3'b111);
    probe(7'd3, 32'h00300000, 0, 0, "R4");
    cfg_rr_en = 1;

    // R5: only two active lines
    cur_req = "R5";
    cfg_active_lines = 4'd2;
    probe(7'd1, 32'h00002000, 0, 0, "R5");
    cfg_active_lines = 4'd0;
    probe(7'd3, 32'h00302000, 1, 20'h00303, "R5");
    refill(7'd4, 20'h00400, 20'h00401, 3'b001);
    probe(7'd4, 32'h00400000, 1, 20'h00401, "R5");
    cfg_active_lines = 4'd15;
    probe(7'd1, 32'h00005000, 1, 20'd105, "R5");
    cfg_active_lines = 4'd8;

    // R10: reserved mode
    cur_req = "R10";
    flush(32'h00000001);
    probe(7'd1, 32'h00005000, 1, 20'd105, "R10");

    // R11: command visible only after its edge
    cur_req = "R11";
    lk_asid = 7'd1; lk_va = 32'h00005000;
    flush_wr = 1; flush_cmd = mk(0, 0, 2'd0, 0);
    rf_valid = 1; rf_asid = 7'd9; rf_vpn = 20'h00999; rf_pfn = 20'h1;
    tick();
    chk(s_hit == 1'b1, "R11", 64'(s_hit), 64'd1);
    flush_wr = 0; rf_valid = 0;
    probe(7'd1, 32'h00005000, 0, 0, "R11");
    probe(7'd9, 32'h00999000, 0, 0, "R11");

    // R6: identifier-qualified full flush
    cur_req = "R6";
    refill(7'd1, 20'h00010, 20'h10, 3'b100);
    refill(7'd2, 20'h00010, 20'h20, 3'b100);
    flush(mk(1, 7'd1, 2'd0, 0));
    probe(7'd1, 32'h00010000, 0, 0, "R6");
    probe(7'd2, 32'h00010000, 1, 20'h20, "R6");

    // R7: section flush
    cur_req = "R7";
    refill(7'd1, 20'h00C01, 20'h31, 3'b100);
    refill(7'd1, 20'h00F02, 20'h32, 3'b100);
    refill(7'd1, 20'h01001, 20'h33, 3'b100);
    flush(mk(0, 0, 2'd2, 32'h00C00000));
    probe(7'd1, 32'h00C01000, 0, 0, "R7");
    probe(7'd1, 32'h00F02000, 0, 0, "R7");
    probe(7'd1, 32'h01001000, 1, 20'h33, "R7");
    refill(7'd3, 20'h01002, 20'h34, 3'b100);
    flush(mk(1, 7'd1, 2'd2, 32'h01000000));
    probe(7'd1, 32'h01001000, 0, 0, "R7");
    probe(7'd3, 32'h01002000, 1, 20'h34, "R7");

    // R8: group flush
    cur_req = "R8";
    refill(7'd2, 20'h02004, 20'h41, 3'b100);
    refill(7'd2, 20'h02007, 20'h42, 3'b100);
    refill(7'd2, 20'h02008, 20'h43, 3'b100);
    flush(mk(0, 0, 2'd3, 32'h02005000));
    probe(7'd2, 32'h02004000, 0, 0, "R8");
    probe(7'd2, 32'h02007000, 0, 0, "R8");
    probe(7'd2, 32'h02008000, 1, 20'h43, "R8");
    flush(mk(1, 7'd7, 2'd3, 32'h02008000));
    probe(7'd2, 32'h02008000, 1, 20'h43, "R8");

    // R12: miss stall and hit-under-miss
    cur_req = "R12";
    cfg_hum = 0;
    lk_valid = 1; lk_asid = 7'd11; lk_va = 32'h0ABCD000;
    tick();
    lk_asid = 7'd2; lk_va = 32'h02008000;
    tick();
    chk(s_rdy == 1'b0, "R12", 64'(s_rdy), 64'd0);
    cfg_hum = 1;
    tick();
    chk(s_rdy == 1'b1, "R12", 64'(s_rdy), 64'd1);
    lk_valid = 0;
    refill(7'd11, 20'h0ABCD, 20'h55, 3'b110);
    probe(7'd11, 32'h0ABCD000, 1, 20'h55, "R12");
    chk(s_rdy == 1'b1, "R12", 64'(s_rdy), 64'd1);

    // R9: narrow identifier field in the 4-identifier build
    cur_req = "R9";
    a_rf_valid = 1; a_rf_asid = 2'd2; a_rf_vpn = 20'h00050; a_rf_pfn = 20'h71;
    tick();
    a_rf_asid = 2'd1; a_rf_pfn = 20'h72;
    tick();
    a_rf_valid = 0;
    a_flush_wr = 1; a_flush_cmd = 32'hC1000000;
    tick();
    a_flush_wr = 0;
    a_lk_va = 32'h00050000; a_lk_asid = 2'd2;
    tick();
    chk(a_lk_hit == 1'b0, "R9", 64'(a_lk_hit), 64'd0);
    a_lk_asid = 2'd1;
    tick();
    chk(a_lk_hit == 1'b1 && a_lk_pfn == 20'h72, "R9",
        64'({a_lk_hit, a_lk_pfn}), 64'({1'b1, 20'h72}));

    // R2: mixed traffic against the model
    cur_req = "R2";
    for (int k = 0; k < 600; k++) begin
      int op;
      logic [19:0] v;
      op = int'($urandom % 8);
      v  = 20'((($urandom % 4) << 10) | ($urandom % 16));
      if (op < 4) begin
        rf_valid = 1; rf_asid = 7'($urandom % 3); rf_vpn = v;
        rf_pfn = 20'($urandom); {rf_rd, rf_wr, rf_ns} = 3'($urandom);
      end else if (op == 4) begin
        flush_wr = 1;
        flush_cmd = mk(1'($urandom), 7'($urandom % 3), 2'($urandom), {v, 12'h0});
      end else if (op == 5) begin
        lk_valid = 1;
      end
      lk_asid = 7'($urandom % 3); lk_va = {v, 12'h0};
      tick();
      rf_valid = 0; flush_wr = 0; lk_valid = 0;
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule